// File: doc/BRIEF.md
# Translation Buffer with Hardware Two-Level Table Walk

This block translates 32-bit virtual addresses into physical addresses for 4 KiB pages. It keeps a small fully associative set of recent translations. When the virtual page number of a request matches a stored translation, the physical address is returned combinationally in the same cycle, and no memory is touched. When no stored translation matches, the block stalls the request and walks a two-level page table in memory through a word-read port. It reads one entry from the root table, whose frame number is given by an input, and then one entry from the leaf table that the root entry points to. A successful walk installs the translation, and the request that is still held then hits. If either entry fetched during the walk is not resident, the block ends the request with a page-fault response and installs nothing.

The requester keeps `req_valid`, `req_write` and `req_vaddr` stable until it sees `req_ready`, which is asserted in the same cycle as `resp_valid`. A write that hits a translation whose modified flag is clear raises `dirty_req` in that cycle, so that the memory copy of the entry can be updated. The buffered copy is marked at the same time. A single-cycle `flush` pulse discards every stored translation.

The walk controller has five states:
- WS_IDLE serves lookups.
- WS_ROOT reads the root entry.
- WS_LEAF reads the leaf entry.
- WS_FILL installs the translation.
- WS_FAULT answers the request with a fault.

It moves through the following transitions:
- WS_IDLE → WS_ROOT on a miss.
- WS_ROOT → WS_LEAF on a resident root entry.
- WS_ROOT → WS_FAULT on a non-resident root entry.
- WS_LEAF → WS_FILL on a resident leaf entry.
- WS_LEAF → WS_FAULT on a non-resident leaf entry.
- WS_FILL → WS_IDLE unconditionally.
- WS_FAULT → WS_IDLE unconditionally.

Top module: `tlb_walker`

## Requirements
- R1: On a hit, `resp_valid` and `req_ready` are high in the same cycle as the request. `resp_paddr` is the stored frame number in bits 31:12 followed by `req_vaddr[11:0]`, and `mem_req` stays low.
- R2: On a miss, the first read address is `{root_base, req_vaddr[31:22], 2'b00}`. The second read address is `{root frame, req_vaddr[21:12], 2'b00}`. Each read holds `mem_req` and `mem_addr` steady until the cycle in which `mem_rvalid` is high.
- R3: Each read is raised in the cycle after the previous step: the cycle after the miss, or the cycle after the root data beat. A translated response is due two cycles after the leaf data beat. A fault response is due one cycle after the faulting data beat.
- R4: A table entry is decoded as follows: bit 0 is resident, bit 1 is modified, bits 4:2 are protection, and bits 31:12 are the frame number. `resp_prot` returns the protection field of the leaf entry on every translated response.
- R5: A root or leaf entry with bit 0 clear ends the request with `resp_valid`, `resp_fault` and `req_ready` high and installs nothing, so a retry of the same address walks again.
- R6: While a walk is in progress, `req_ready` stays low and the request is held.
- R7: A fill uses the lowest-numbered empty slot. When all 8 slots are full, it uses a round-robin pointer that starts at slot 0 and advances by one on each such fill.
- R8: A write that hits an entry whose modified flag is clear raises `dirty_req` in the response cycle and marks the buffered copy, so that later writes to that page do not raise it. Reads never raise it.
- R9: A flush pulse empties every slot within one cycle and returns the round-robin pointer to slot 0. The next access to any page walks again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard all stored translations |
| root_base | input | 20 | Frame number of the root table |
| req_valid | input | 1 | Translation request present |
| req_write | input | 1 | Request is a write |
| req_vaddr | input | 32 | Virtual address |
| req_ready | output | 1 | Request consumed this cycle |
| resp_valid | output | 1 | Response present this cycle |
| resp_fault | output | 1 | Response is a page fault |
| resp_paddr | output | 32 | Physical address (zero on fault) |
| resp_prot | output | 3 | Protection bits of the translation |
| dirty_req | output | 1 | Write hit on a page not yet marked modified |
| mem_req | output | 1 | Table read request |
| mem_addr | output | 32 | Table read byte address |
| mem_rvalid | input | 1 | Read data beat |
| mem_rdata | input | 32 | Read data word |

## Verification
A hit is due in the cycle it is presented. With a memory that answers one cycle after a read is raised, a full walk delivers its translated response six cycles after the miss, a root fault three cycles after, and a leaf fault five cycles after. The bench presents each request just after a falling edge and looks again one time unit later at every falling edge, counting the edges until `resp_valid` appears. It compares that count with the latency its own behavioural model predicts from the table contents and the model's slot occupancy. On every stalled edge it confirms that `req_ready` is low, and it compares the sequence of read addresses with the two addresses the walk must produce.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VA_W      = 32;
    localparam int OFF_W     = 12;
    localparam int IDX_W     = 10;
    localparam int VPN_W     = VA_W - OFF_W;
    localparam int PFN_W     = VA_W - OFF_W;
    localparam int PROT_W    = 3;

    localparam int PTE_RES   = 0;
    localparam int PTE_MOD   = 1;
    localparam int PTE_PROT  = 2;

    typedef enum logic [2:0] {
        WS_IDLE,
        WS_ROOT,
        WS_LEAF,
        WS_FILL,
        WS_FAULT
    } walk_state_e;
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 flush,
    input  logic [VPN_W-1:0]     lookup_vpn,
    input  logic                 mark_dirty,
    input  logic                 fill_en,
    input  logic [VPN_W-1:0]     fill_vpn,
    input  logic [PFN_W-1:0]     fill_pfn,
    input  logic [PROT_W-1:0]    fill_prot,
    input  logic                 fill_dirty,
    output logic                 hit,
    output logic [PFN_W-1:0]     hit_pfn,
    output logic [PROT_W-1:0]    hit_prot,
    output logic                 hit_dirty,
    output logic [ENTRIES-1:0]   hit_vec,
    output logic [ENTRIES-1:0]   valid_vec
);
    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0] valid_q;
    logic [ENTRIES-1:0] dirty_q;
    logic [VPN_W-1:0]   vpn_q  [ENTRIES];
    logic [PFN_W-1:0]   pfn_q  [ENTRIES];
    logic [PROT_W-1:0]  prot_q [ENTRIES];
    logic [PTR_W-1:0]   rr_q;
    logic [PTR_W-1:0]   victim;
    logic               have_empty;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = valid_q[g] && (vpn_q[g] == lookup_vpn);
    end

    assign hit       = |hit_vec;
    assign valid_vec = valid_q;

    always_comb begin
        hit_pfn   = '0;
        hit_prot  = '0;
        hit_dirty = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) begin
                hit_pfn   = hit_pfn   | pfn_q[i];
                hit_prot  = hit_prot  | prot_q[i];
                hit_dirty = hit_dirty | dirty_q[i];
            end
        end
    end

    always_comb begin
        victim     = rr_q;
        have_empty = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!valid_q[i] && !have_empty) begin
                victim     = PTR_W'(i);
                have_empty = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            valid_q <= '0;
            rr_q    <= '0;
        end else if (fill_en) begin
            valid_q[victim] <= 1'b1;
            if (!have_empty) begin
                rr_q <= (rr_q == PTR_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dirty_q <= '0;
        end else if (fill_en && !flush) begin
            dirty_q[victim] <= fill_dirty;
        end else if (mark_dirty) begin
            dirty_q <= dirty_q | hit_vec;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en && !flush) begin
            vpn_q[victim]  <= fill_vpn;
            pfn_q[victim]  <= fill_pfn;
            prot_q[victim] <= fill_prot;
        end
    end
endmodule

// File: rtl/tlb_walk_fsm.sv
module tlb_walk_fsm
    import tlb_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               req_valid,
    input  logic               hit,
    input  logic [VPN_W-1:0]   req_vpn,
    input  logic [PFN_W-1:0]   root_base,
    input  logic               mem_rvalid,
    input  logic [VA_W-1:0]    mem_rdata,
    output walk_state_e        state,
    output logic               mem_req,
    output logic [VA_W-1:0]    mem_addr,
    output logic               fill_en,
    output logic [PFN_W-1:0]   fill_pfn,
    output logic [PROT_W-1:0]  fill_prot,
    output logic               fill_dirty
);
    walk_state_e      state_q, state_d;
    logic [PFN_W-1:0] leaf_base_q;
    logic [VA_W-1:0]  pte_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WS_IDLE:  if (req_valid && !hit) state_d = WS_ROOT;
            WS_ROOT:  if (mem_rvalid) state_d = mem_rdata[PTE_RES] ? WS_LEAF : WS_FAULT;
            WS_LEAF:  if (mem_rvalid) state_d = mem_rdata[PTE_RES] ? WS_FILL : WS_FAULT;
            WS_FILL:  state_d = WS_IDLE;
            WS_FAULT: state_d = WS_IDLE;
            default:  state_d = WS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            leaf_base_q <= '0;
            pte_q       <= '0;
        end else begin
            if (state_q == WS_ROOT && mem_rvalid) leaf_base_q <= mem_rdata[VA_W-1:OFF_W];
            if (state_q == WS_LEAF && mem_rvalid) pte_q       <= mem_rdata;
        end
    end

    always_comb begin
        mem_req  = 1'b0;
        mem_addr = '0;
        fill_en  = 1'b0;
        unique case (state_q)
            WS_ROOT: begin
                mem_req  = 1'b1;
                mem_addr = {root_base, req_vpn[VPN_W-1 -: IDX_W], 2'b00};
            end
            WS_LEAF: begin
                mem_req  = 1'b1;
                mem_addr = {leaf_base_q, req_vpn[IDX_W-1:0], 2'b00};
            end
            WS_FILL: fill_en = !flush;
            default: ;
        endcase
    end

    assign state      = state_q;
    assign fill_pfn   = pte_q[VA_W-1:OFF_W];
    assign fill_prot  = pte_q[PTE_PROT +: PROT_W];
    assign fill_dirty = pte_q[PTE_MOD];
endmodule

// File: rtl/tlb_walker.sv
module tlb_walker
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [19:0]       root_base,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [31:0]       req_vaddr,
    output logic              req_ready,
    output logic              resp_valid,
    output logic              resp_fault,
    output logic [31:0]       resp_paddr,
    output logic [2:0]        resp_prot,
    output logic              dirty_req,
    output logic              mem_req,
    output logic [31:0]       mem_addr,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata
);
    walk_state_e        state;
    logic               hit;
    logic [PFN_W-1:0]   hit_pfn;
    logic [PROT_W-1:0]  hit_prot;
    logic               hit_dirty;
    logic [ENTRIES-1:0] hit_vec;
    logic [ENTRIES-1:0] valid_vec;
    logic               fill_en;
    logic [PFN_W-1:0]   fill_pfn;
    logic [PROT_W-1:0]  fill_prot;
    logic               fill_dirty;
    logic               served;
    logic [VPN_W-1:0]   req_vpn;

    assign req_vpn = req_vaddr[VA_W-1:OFF_W];

    tlb_cam #(.ENTRIES(ENTRIES)) u_cam (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .lookup_vpn (req_vpn),
        .mark_dirty (dirty_req),
        .fill_en    (fill_en),
        .fill_vpn   (req_vpn),
        .fill_pfn   (fill_pfn),
        .fill_prot  (fill_prot),
        .fill_dirty (fill_dirty),
        .hit        (hit),
        .hit_pfn    (hit_pfn),
        .hit_prot   (hit_prot),
        .hit_dirty  (hit_dirty),
        .hit_vec    (hit_vec),
        .valid_vec  (valid_vec)
    );

    tlb_walk_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .req_valid  (req_valid),
        .hit        (hit),
        .req_vpn    (req_vpn),
        .root_base  (root_base),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .state      (state),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .fill_en    (fill_en),
        .fill_pfn   (fill_pfn),
        .fill_prot  (fill_prot),
        .fill_dirty (fill_dirty)
    );

    assign served     = (state == WS_IDLE) && req_valid && hit;
    assign resp_fault = (state == WS_FAULT);
    assign resp_valid = served || resp_fault;
    assign req_ready  = resp_valid;
    assign resp_paddr = served ? {hit_pfn, req_vaddr[OFF_W-1:0]} : '0;
    assign resp_prot  = served ? hit_prot : '0;
    assign dirty_req  = served && req_write && !hit_dirty;
endmodule

// File: rtl/tlb_walker_chk.sv
module tlb_walker_chk #(
    parameter int ENTRIES = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               flush,
    input logic               req_valid,
    input logic               req_write,
    input logic [31:0]        req_vaddr,
    input logic               req_ready,
    input logic               resp_valid,
    input logic               resp_fault,
    input logic [31:0]        resp_paddr,
    input logic               dirty_req,
    input logic               mem_req,
    input logic [31:0]        mem_addr,
    input logic               mem_rvalid,
    input logic [ENTRIES-1:0] hit_vec,
    input logic [ENTRIES-1:0] valid_vec
);
    a_r1_hit_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_fault) |-> !mem_req);

    a_r1_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_fault) |-> (resp_paddr[11:0] == req_vaddr[11:0]));

    a_r2_read_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

    a_r5_fault_no_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_fault && !flush) |=> $stable(valid_vec));

    a_r6_stall_in_walk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready);

    a_r7_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    a_r8_dirty_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        dirty_req |-> (resp_valid && req_valid && req_write && !resp_fault));

    a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_vec == '0));
endmodule

bind tlb_walker tlb_walker_chk #(.ENTRIES(ENTRIES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_vaddr  (req_vaddr),
    .req_ready  (req_ready),
    .resp_valid (resp_valid),
    .resp_fault (resp_fault),
    .resp_paddr (resp_paddr),
    .dirty_req  (dirty_req),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .hit_vec    (hit_vec),
    .valid_vec  (valid_vec)
);

// File: tb/test_tlb_walker.sv
`timescale 1ns/1ps
module test_tlb_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic [19:0] root_base = 20'h00100;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        req_ready, resp_valid, resp_fault, dirty_req, mem_req;
    logic [31:0] resp_paddr, mem_addr;
    logic [2:0]  resp_prot;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    int reads  = 0;

    logic [31:0] table_mem [logic [31:0]];
    logic [31:0] addr_log [$];

    logic [19:0] m_vpn [8];
    bit          m_val [8];
    bit          m_dty [8];
    int          m_ptr = 0;

    always #10 clk = ~clk;

    tlb_walker i_tlb_walker (
        .clk(clk), .rst_n(rst_n), .flush(flush), .root_base(root_base),
        .req_valid(req_valid), .req_write(req_write), .req_vaddr(req_vaddr),
        .req_ready(req_ready), .resp_valid(resp_valid), .resp_fault(resp_fault),
        .resp_paddr(resp_paddr), .resp_prot(resp_prot), .dirty_req(dirty_req),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] rd_word(logic [31:0] a);
        if (table_mem.exists(a)) return table_mem[a];
        return 32'h0;
    endfunction

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (mem_req && !mem_rvalid) begin
            mem_rvalid <= 1'b1;
            mem_rdata  <= rd_word(mem_addr);
            addr_log.push_back(mem_addr);
            reads <= reads + 1;
        end else begin
            mem_rvalid <= 1'b0;
        end
    end

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int m_find(logic [19:0] vpn);
        for (int i = 0; i < 8; i++) if (m_val[i] && m_vpn[i] == vpn) return i;
        return -1;
    endfunction

    function automatic void m_install(logic [19:0] vpn, bit d);
        int slot = -1;
        for (int i = 0; i < 8; i++) if (!m_val[i] && slot < 0) slot = i;
        if (slot < 0) begin
            slot = m_ptr;
            m_ptr = (m_ptr + 1) % 8;
        end
        m_val[slot] = 1; m_vpn[slot] = vpn; m_dty[slot] = d;
    endfunction

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        for (int i = 0; i < 8; i++) m_val[i] = 0;
        m_ptr = 0;
    endtask

    task automatic access(logic [31:0] va, bit wr, string req);
        logic [31:0] re, le, exp_pa;
        logic [19:0] vpn = va[31:12];
        int slot = m_find(vpn);
        int exp_lat, lat = 0;
        bit exp_fault = 0, exp_dirty = 0, stall_ok = 1;
        logic [2:0] exp_prot;
        logic [31:0] a_root, a_leaf;
        a_root = {root_base, va[31:22], 2'b00};
        re = rd_word(a_root);
        a_leaf = {re[31:12], va[21:12], 2'b00};
        le = rd_word(a_leaf);
        if (slot >= 0) begin
            exp_lat = 0;
        end else if (!re[0]) begin
            exp_lat = 3; exp_fault = 1;
        end else if (!le[0]) begin
            exp_lat = 5; exp_fault = 1;
        end else begin
            exp_lat = 6;
            m_install(vpn, le[1]);
            slot = m_find(vpn);
        end
        exp_pa   = exp_fault ? 32'h0 : {le[31:12], va[11:0]};
        exp_prot = exp_fault ? 3'd0 : le[4:2];
        if (!exp_fault && wr && !m_dty[slot]) begin
            exp_dirty = 1; m_dty[slot] = 1;
        end
        addr_log.delete();
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_vaddr = va;
        #1;
        while (!resp_valid && lat < 40) begin
            if (req_ready) stall_ok = 0;
            @(negedge clk); #1;
            lat++;
        end
        check(lat == exp_lat, req, "latency", lat, exp_lat);
        check(resp_fault == exp_fault, req, "fault", resp_fault, exp_fault);
        check(req_ready == resp_valid, "R5", "ready with response", req_ready, 1);
        if (!exp_fault) begin
            check(resp_paddr == exp_pa, "R1", "paddr", resp_paddr, exp_pa);
            check(resp_prot == exp_prot, "R4", "prot", resp_prot, exp_prot);
        end
        check(dirty_req == exp_dirty, "R8", "dirty_req", dirty_req, exp_dirty);
        if (exp_lat > 0) begin
            check(stall_ok, "R6", "ready low while walking", !stall_ok, 0);
            check(addr_log.size() > 0 && addr_log[0] == a_root, "R2", "root read address",
                  addr_log.size() > 0 ? addr_log[0] : 0, a_root);
            if (exp_lat != 3)
                check(addr_log.size() > 1 && addr_log[1] == a_leaf, "R2", "leaf read address",
                      addr_log.size() > 1 ? addr_log[1] : 0, a_leaf);
        end
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    function automatic logic [31:0] va_of(int ridx, int lidx, int off);
        return {ridx[9:0], lidx[9:0], off[11:0]};
    endfunction

    initial begin
        while (cycles < 100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=<100000", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int r0;
        table_mem[32'h0010_0004] = {20'h00201, 12'h001};
        for (int k = 0; k < 12; k++)
            table_mem[32'h0020_1000 + k * 4] =
                {20'h50000 + 20'(k), 7'd0, 3'(k), (k == 3) ? 1'b1 : 1'b0, 1'b1};
        table_mem[32'h0020_1000 + 20 * 4] = {20'h60000, 12'h01c};
        for (int i = 0; i < 8; i++) begin m_val[i] = 0; m_dty[i] = 0; m_vpn[i] = '0; end

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(resp_valid == 0, "R1", "reset resp_valid", resp_valid, 0);
        check(mem_req == 0, "R2", "reset mem_req", mem_req, 0);
        check(dirty_req == 0, "R8", "reset dirty_req", dirty_req, 0);

        access(va_of(1, 0, 12'h3a4), 0, "R3");
        r0 = reads;
        access(va_of(1, 0, 12'h7ff), 0, "R1");
        check(reads == r0, "R1", "no memory read on hit", reads, r0);
        access(va_of(1, 0, 12'h010), 1, "R8");
        access(va_of(1, 0, 12'h020), 1, "R8");
        access(va_of(1, 0, 12'h030), 0, "R8");
        access(va_of(1, 3, 12'h000), 0, "R3");
        access(va_of(1, 3, 12'h004), 1, "R8");

        access(va_of(2, 5, 12'h100), 0, "R5");
        access(va_of(2, 5, 12'h100), 0, "R5");
        access(va_of(1, 20, 12'h0ff), 1, "R5");
        access(va_of(1, 20, 12'h0ff), 0, "R5");

        do_flush();
        access(va_of(1, 0, 12'h001), 0, "R9");
        access(va_of(1, 3, 12'h002), 0, "R9");

        for (int k = 1; k < 8; k++) access(va_of(1, k, 12'h040), 0, "R7");
        access(va_of(1, 8, 12'h050), 0, "R7");
        access(va_of(1, 1, 12'h060), 0, "R7");
        access(va_of(1, 0, 12'h070), 0, "R7");
        access(va_of(1, 4, 12'h080), 0, "R7");
        access(va_of(1, 9, 12'h090), 1, "R7");
        access(va_of(1, 3, 12'h0a0), 0, "R7");

        do_flush();
        access(va_of(1, 4, 12'h0b0), 0, "R9");

        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule